// File: doc/BRIEF.md
# Power-Gated Multi-Channel Frame Packer

This block assembles one output frame per conversion from a set of per-channel sample words. It places the words on a single time-multiplexed serial line or on one serial lane per channel. Each channel supplies a sample word together with a powered flag and a data-valid flag. A one-cycle frame-start strobe latches the slot contents, the mode and the occupied-slot count. The serial stream then begins on the following cycle and carries one bit per clock, most significant bit first.

Three placements are supported. Fixed-position TDM keeps every channel in its own slot and sends zeros in the slot of a channel that is switched off. Dynamic-position TDM closes the gaps: every channel that is both powered and valid is packed toward the start of the frame in ascending index order, so the frame shrinks when channels sleep. A channel that has just woken joins the frame only once its valid flag is set. In discrete mode each channel drives its own lane, and the lane of an unpowered channel is held at zero. Switching one channel off or on never alters the words that the other running channels deliver.

Top module: `frame_packer_top`

## Requirements
- R1: The mode input uses 0 for discrete, 1 for fixed-position TDM and 2 for dynamic-position TDM. Code 3 behaves exactly as code 1.
- R2: In fixed-position mode, slot i holds channel i's sample when channel i is powered and all zeros otherwise. The slot count equals the channel count.
- R3: In dynamic-position mode, the channels whose powered and valid flags are both high fill slots 0, 1, 2 … in ascending channel-index order. The slot count equals the number of such channels.
- R4: In dynamic-position mode, a channel that is powered but not valid is excluded from the frame. The slots after the last included channel hold zeros.
- R5: In discrete mode, slot i holds channel i's sample when channel i is powered and zeros otherwise. Lane i of the discrete output shifts that slot out MSB first over SAMPLE_W cycles, and the TDM line stays low.
- R6: Slot data, slot count and mode are captured only at a frame-start strobe. Changes to samples, flags or mode after that strobe have no effect until the next strobe.
- R7: In TDM modes, the serial line carries slot 0 to slot count-1, each MSB first, one bit per cycle. The stream starts on the cycle after the strobe. Once the last bit has been sent, frame_busy falls and the line and lanes return to zero.
- R8: After a synchronous active-high reset, slot data, slot count, frame_busy, the TDM line and all lanes are zero.
- R9: A dynamic-position frame with no included channel sends no bits: frame_busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe that captures a new frame |
| mode | input | 2 | Placement mode (0 discrete, 1 fixed, 2 dynamic, 3 fixed) |
| ch_powered | input | NUM_CH | Per-channel powered flag |
| ch_valid | input | NUM_CH | Per-channel data-valid flag |
| samples | input | NUM_CH*SAMPLE_W | Channel i sample at bits [i*SAMPLE_W +: SAMPLE_W] |
| slot_data | output | NUM_CH*SAMPLE_W | Captured slot j at bits [j*SAMPLE_W +: SAMPLE_W] |
| slot_count | output | $clog2(NUM_CH+1) | Number of occupied slots in the captured frame |
| frame_busy | output | 1 | High while the captured frame is being shifted out |
| tdm_out | output | 1 | Time-multiplexed serial line |
| disc_out | output | NUM_CH | Per-channel serial lanes for discrete mode |

## Verification
The bench builds the block with three channels and 8-bit samples. This is small enough to sweep all 64 combinations of powered and valid flags in all four mode codes. Every packing pattern is reached, including the empty dynamic frame, single-slot frames and full frames. The short sample width keeps each full serial stream short, so every frame's bit stream is compared against the expected one. Right after each capture, the bench inverts all inputs to show that the captured frame is unaffected.

// File: rtl/frame_packer_pkg.sv
package frame_packer_pkg;

    typedef enum logic [1:0] {
        PM_DISCRETE = 2'd0,
        PM_FIXED    = 2'd1,
        PM_DYNAMIC  = 2'd2
    } place_mode_e;

    function automatic place_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'd0:    return PM_DISCRETE;
            2'd2:    return PM_DYNAMIC;
            default: return PM_FIXED;
        endcase
    endfunction

    function automatic logic is_discrete(input place_mode_e m);
        return m == PM_DISCRETE;
    endfunction

endpackage

// File: rtl/frame_slot_mapper.sv
module frame_slot_mapper
    import frame_packer_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 24,
    localparam int CNT_W   = $clog2(NUM_CH + 1)
) (
    input  place_mode_e                    mode,
    input  logic [NUM_CH-1:0]              powered,
    input  logic [NUM_CH-1:0]              valid,
    input  logic [NUM_CH*SAMPLE_W-1:0]     samples,
    output logic [NUM_CH*SAMPLE_W-1:0]     slots,
    output logic [CNT_W-1:0]               count
);

    logic [SAMPLE_W-1:0] smp [NUM_CH];
    logic [NUM_CH-1:0]   incl;
    logic [CNT_W-1:0]    rank [NUM_CH];
    logic [CNT_W-1:0]    rank_acc;
    logic                dyn;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_unpack
        assign smp[i] = samples[i*SAMPLE_W +: SAMPLE_W];
    end

    assign dyn = (mode == PM_DYNAMIC);

    always_comb begin
        rank_acc = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            incl[i] = dyn ? (powered[i] & valid[i]) : powered[i];
            rank[i] = rank_acc;
            rank_acc = rank_acc + CNT_W'(incl[i]);
        end
    end

    always_comb begin
        slots = '0;
        for (int j = 0; j < NUM_CH; j++) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (dyn ? (incl[i] && rank[i] == CNT_W'(j)) : (i == j && incl[i]))
                    slots[j*SAMPLE_W +: SAMPLE_W] = slots[j*SAMPLE_W +: SAMPLE_W] | smp[i];
            end
        end
    end

    assign count = dyn ? rank_acc : CNT_W'(NUM_CH);

endmodule

// File: rtl/frame_capture_reg.sv
module frame_capture_reg
    import frame_packer_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 24,
    localparam int CNT_W   = $clog2(NUM_CH + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           capture,
    input  place_mode_e                    in_mode,
    input  logic [NUM_CH*SAMPLE_W-1:0]     in_slots,
    input  logic [CNT_W-1:0]               in_count,
    output place_mode_e                    cur_mode,
    output logic [NUM_CH*SAMPLE_W-1:0]     cur_slots,
    output logic [CNT_W-1:0]               cur_count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_mode  <= PM_FIXED;
            cur_slots <= '0;
            cur_count <= '0;
        end else if (capture) begin
            cur_mode  <= in_mode;
            cur_slots <= in_slots;
            cur_count <= in_count;
        end
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(cur_slots) && $stable(cur_count) && $stable(cur_mode));

endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
    import frame_packer_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 24,
    localparam int CNT_W   = $clog2(NUM_CH + 1),
    localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int BIT_W   = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           load,
    input  place_mode_e                    load_mode,
    input  logic [CNT_W-1:0]               load_count,
    input  place_mode_e                    cur_mode,
    input  logic [CNT_W-1:0]               cur_count,
    input  logic [NUM_CH*SAMPLE_W-1:0]     cur_slots,
    output logic                           busy,
    output logic                           tdm_out,
    output logic [NUM_CH-1:0]              disc_out
);

    logic [SAMPLE_W-1:0] slot_arr [NUM_CH];
    logic [IDX_W-1:0]    slot_idx;
    logic [BIT_W-1:0]    bit_idx;
    logic [BIT_W-1:0]    sel;
    logic                last_bit;
    logic                last_slot;
    logic                disc_now;

    for (genvar j = 0; j < NUM_CH; j++) begin : g_slots
        assign slot_arr[j] = cur_slots[j*SAMPLE_W +: SAMPLE_W];
    end

    assign sel       = BIT_W'(SAMPLE_W - 1) - bit_idx;
    assign last_bit  = (bit_idx == BIT_W'(SAMPLE_W - 1));
    assign last_slot = (CNT_W'(slot_idx) == cur_count - CNT_W'(1));
    assign disc_now  = is_discrete(cur_mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            slot_idx <= '0;
            bit_idx  <= '0;
        end else if (load) begin
            busy     <= is_discrete(load_mode) || (load_count != '0);
            slot_idx <= '0;
            bit_idx  <= '0;
        end else if (busy) begin
            if (last_bit) begin
                bit_idx <= '0;
                if (disc_now || last_slot)
                    busy <= 1'b0;
                else
                    slot_idx <= slot_idx + IDX_W'(1);
            end else begin
                bit_idx <= bit_idx + BIT_W'(1);
            end
        end
    end

    always_comb begin
        tdm_out = busy && !disc_now && slot_arr[slot_idx][sel];
        for (int i = 0; i < NUM_CH; i++)
            disc_out[i] = busy && disc_now && slot_arr[i][sel];
    end

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tdm_out && (disc_out == '0));

    assert_disc_line_low_R5: assert property (@(posedge clk) disable iff (rst)
        busy && disc_now |-> !tdm_out);

    assert_slot_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        busy && !disc_now |-> CNT_W'(slot_idx) < cur_count);

endmodule

// File: rtl/frame_packer_top.sv
module frame_packer_top
    import frame_packer_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 24,
    localparam int CNT_W   = $clog2(NUM_CH + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           frame_start,
    input  logic [1:0]                     mode,
    input  logic [NUM_CH-1:0]              ch_powered,
    input  logic [NUM_CH-1:0]              ch_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0]     samples,
    output logic [NUM_CH*SAMPLE_W-1:0]     slot_data,
    output logic [CNT_W-1:0]               slot_count,
    output logic                           frame_busy,
    output logic                           tdm_out,
    output logic [NUM_CH-1:0]              disc_out
);

    place_mode_e                  in_mode;
    place_mode_e                  cur_mode;
    logic [NUM_CH*SAMPLE_W-1:0]   next_slots;
    logic [CNT_W-1:0]             next_count;

    assign in_mode = decode_mode(mode);

    frame_slot_mapper #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_map (
        .mode    (in_mode),
        .powered (ch_powered),
        .valid   (ch_valid),
        .samples (samples),
        .slots   (next_slots),
        .count   (next_count)
    );

    frame_capture_reg #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .capture   (frame_start),
        .in_mode   (in_mode),
        .in_slots  (next_slots),
        .in_count  (next_count),
        .cur_mode  (cur_mode),
        .cur_slots (slot_data),
        .cur_count (slot_count)
    );

    frame_serializer #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .load       (frame_start),
        .load_mode  (in_mode),
        .load_count (next_count),
        .cur_mode   (cur_mode),
        .cur_count  (slot_count),
        .cur_slots  (slot_data),
        .busy       (frame_busy),
        .tdm_out    (tdm_out),
        .disc_out   (disc_out)
    );

    assert_fixed_count_R2: assert property (@(posedge clk) disable iff (rst)
        frame_start && (mode[0] == 1'b1) |=> slot_count == CNT_W'(NUM_CH));

    assert_dyn_count_R3: assert property (@(posedge clk) disable iff (rst)
        frame_start && (mode == 2'd2) |=>
            slot_count == CNT_W'($countones($past(ch_powered & ch_valid))));

    assert_empty_dyn_R9: assert property (@(posedge clk) disable iff (rst)
        frame_start && (mode == 2'd2) && ((ch_powered & ch_valid) == '0) |=> !frame_busy);

    assert_busy_start_R7: assert property (@(posedge clk) disable iff (rst)
        frame_start && (mode != 2'd2) |=> frame_busy);

endmodule

// File: tb/tb_frame_packer_top.sv
module tb_frame_packer_top;
    localparam int NCH   = 3;
    localparam int SW    = 8;
    localparam int CW    = $clog2(NCH + 1);
    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_start = 1'b0;
    logic [1:0]        mode = 2'd0;
    logic [NCH-1:0]    ch_powered = '0;
    logic [NCH-1:0]    ch_valid = '0;
    logic [NCH*SW-1:0] samples = '0;
    logic [NCH*SW-1:0] slot_data;
    logic [CW-1:0]     slot_count;
    logic              frame_busy;
    logic              tdm_out;
    logic [NCH-1:0]    disc_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_P/2) clk = ~clk;

    frame_packer_top #(.NUM_CH(NCH), .SAMPLE_W(SW)) dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .mode(mode),
        .ch_powered(ch_powered), .ch_valid(ch_valid), .samples(samples),
        .slot_data(slot_data), .slot_count(slot_count), .frame_busy(frame_busy),
        .tdm_out(tdm_out), .disc_out(disc_out)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fail++;
                n_checks++;
                $display("FAIL watchdog actual=%0d expected<100000", cycles);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        logic [NCH*SW-1:0] exp_slots;
        int                exp_cnt;
        int                k;
        int                bad;
        logic              dyn;
        logic              disc;
        string             tag;

        repeat (3) @(negedge clk);
        // R8: reset state
        chk(slot_data == '0 && slot_count == '0 && !frame_busy && !tdm_out && disc_out == '0,
            "R8 reset state", {slot_count, frame_busy, tdm_out, disc_out}, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int f = 0; f < 256; f++) begin
            mode       = 2'(f / 64);
            ch_powered = NCH'(f % 8);
            ch_valid   = NCH'((f / 8) % 8);
            for (int i = 0; i < NCH; i++)
                samples[i*SW +: SW] = SW'(f * 37 + i * 91 + 17) | SW'(8'h10);
            dyn  = (mode == 2'd2);
            disc = (mode == 2'd0);
            tag  = disc ? "R5" : (dyn ? "R3/R4" : (mode == 2'd3 ? "R1" : "R2"));

            exp_slots = '0;
            k = 0;
            for (int i = 0; i < NCH; i++) begin
                if (dyn) begin
                    if (ch_powered[i] && ch_valid[i]) begin
                        exp_slots[k*SW +: SW] = samples[i*SW +: SW];
                        k++;
                    end
                end else if (ch_powered[i]) begin
                    exp_slots[i*SW +: SW] = samples[i*SW +: SW];
                end
            end
            exp_cnt = dyn ? k : NCH;

            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
            // R6: disturb every input after capture
            ch_powered = ~ch_powered;
            ch_valid   = ~ch_valid;
            mode       = mode ^ 2'd1;
            samples    = ~samples;

            chk(slot_data == exp_slots, {tag, " slot data (R6)"}, 64'(slot_data), 64'(exp_slots));
            chk(slot_count == CW'(exp_cnt), {tag, " slot count"}, 64'(slot_count), 64'(exp_cnt));

            bad = 0;
            if (disc) begin
                for (int b = 0; b < SW; b++) begin
                    if (b > 0) @(negedge clk);
                    for (int i = 0; i < NCH; i++)
                        if (disc_out[i] !== exp_slots[i*SW + SW - 1 - b]) bad++;
                    if (tdm_out !== 1'b0) bad++;
                end
                chk(bad == 0, "R5 discrete lanes", 64'(bad), 0);
            end else begin
                for (int b = 0; b < exp_cnt * SW; b++) begin
                    if (b > 0) @(negedge clk);
                    if (tdm_out !== exp_slots[(b / SW) * SW + SW - 1 - (b % SW)]) bad++;
                    if (!frame_busy) bad++;
                end
                chk(bad == 0, dyn ? "R7 R4 dynamic stream" : "R7 fixed stream", 64'(bad), 0);
                if (dyn && exp_cnt == 0)
                    chk(!frame_busy, "R9 empty frame idle", 64'(frame_busy), 0);
            end
            @(negedge clk);
            chk(!frame_busy && !tdm_out && disc_out == '0, "R7 end of frame",
                {frame_busy, tdm_out, disc_out}, 0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule